// File: doc/BRIEF.md
# Source Address Match Auto-Pending Engine

This block sits beside the receive path of an IEEE 802.15.4-style radio. When the frame parser has extracted the source address of an incoming frame, it pulses a strobe together with the address, its addressing mode and a flag that says whether the frame is a data request MAC command. The engine compares the address against a table of 24 short (16-bit) and 12 extended (64-bit) entries. One clock later it presents a match flag, the index of the lowest matching entry, and the decision on whether the outgoing acknowledgment should carry the frame-pending bit.

Software reaches the table, the control bits and four enable words through a byte-wide register bus. Writes take effect on the clock edge. Reads are combinational. Each enable word is exposed as three consecutive byte registers. The extended words hold entry n on the even bit 2n; the odd bits ignore writes and read back as a copy of their even neighbour. The lookup sees each register as it will be after a write in the same cycle. Clearing an enable therefore removes an entry from the very lookup that coincides with it.

The control flow is a two-state machine. ST_IDLE means no result is presented. ST_RESULT means a registered result is on the outputs. The transition GO_RESULT (ST_IDLE to ST_RESULT) and the transition HOLD_RESULT (ST_RESULT to ST_RESULT) are both taken whenever the strobe is high. The transition GO_IDLE (ST_RESULT to ST_IDLE) and the self-loop STAY_IDLE are taken when it is low.

Top module: `srcm_engine`

## Requirements
- R1: After reset, no result is presented. The control register at 0x90 reads 0x07, and every enable byte register (0x91 to 0x9C) reads 0x00.
- R2: The control register holds match enable in bit 0, auto-pending enable in bit 1 and data-request-only in bit 2. Bits 7:3 always read 0, whatever was written to them.
- R3: The short-enable word uses 0x91 for bits 7:0, 0x92 for bits 15:8 and 0x93 for bits 23:16. The short-pending word uses 0x97, 0x98 and 0x99 in the same way. Bit i belongs to short entry i, and every bit reads back as written.
- R4: The extended-enable word (0x94 to 0x96) and the extended-pending word (0x9A to 0x9C) hold extended entry n on word bit 2n. Writes to odd bits are ignored. On a read, each odd bit 2n+1 returns the value of bit 2n.
- R5: A result appears exactly one clock after the strobe, with res_valid high for one cycle per strobe, and back-to-back strobes give back-to-back results. While res_valid is low, every result flag is 0 and the index is 0.
- R6: src_mode 2'b10 compares src_addr[15:0] with the short entries only. src_mode 2'b11 compares all 64 bits with the extended entries only. Modes 2'b00 and 2'b01 never match.
- R7: An entry matches when its address-enable bit is set and its address equals the key. res_idx reports the lowest-numbered matching entry, and 0 when nothing matches.
- R8: res_pend is 1 only when all of these hold: filt_en is high, match enable is set, auto-pending is set, the data-request condition holds, and at least one qualifying entry matches.
- R9: When data-request-only is 0, frames that are not data requests can set res_pend. When it is 1, they cannot.
- R10: A matching entry qualifies only if its pending-enable bit is also set. res_nopend is 1 when there is a match but no matching entry qualifies.
- R11: While filt_en is low, nothing matches and res_pend stays 0, whatever the match-enable bit holds.
- R12: An enable write in the same cycle as the strobe already applies to that lookup.
- R13: Short entry i occupies bytes 2i (low) and 2i+1 (high). Extended entry n occupies bytes 0x30+8n to 0x30+8n+7, least significant byte first. Table bytes read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_en | input | 1 | Frame filtering enabled |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| src_valid | input | 1 | Source address valid strobe |
| src_mode | input | 2 | Source addressing mode |
| src_addr | input | 64 | Source address; short uses bits 15:0 |
| src_is_dreq | input | 1 | Frame is a data request command |
| res_valid | output | 1 | Result valid, one clock after the strobe |
| res_hit | output | 1 | Source address matched an enabled entry |
| res_idx | output | 5 | Lowest matching entry index |
| res_pend | output | 1 | Set the frame-pending bit in the acknowledgment |
| res_nopend | output | 1 | Matched, but no matching entry qualifies for pending |

## Verification
A register write and a lookup can fall in the same cycle. The case that matters is software clearing an entry's enable while a frame's strobe arrives. The bench provokes it by driving bus_we to the short-enable high byte in the same cycle as a strobe whose address hits only that entry. It expects res_hit to be 0 in the following cycle, and it then reads the byte back to confirm that the write landed.

// File: rtl/srcm_pkg.sv
package srcm_pkg;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_RSVD  = 2'b01,
        SRC_SHORT = 2'b10,
        SRC_EXT   = 2'b11
    } srcmode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    localparam int CTRL_BITS   = 3;
    localparam int CB_MATCH    = 0;
    localparam int CB_AUTOPEND = 1;
    localparam int CB_DREQONLY = 2;

endpackage

// File: rtl/srcm_flagword.sv
module srcm_flagword #(
    parameter int N      = 24,
    parameter int AW     = 8,
    parameter int BASE   = 145,
    parameter bit PAIRED = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]   wdata,
    output logic [N-1:0] q_nx,
    output logic [7:0]   rdata
);
    localparam int BITS  = PAIRED ? 2 * N : N;
    localparam int BYTES = (BITS + 7) / 8;

    logic [N-1:0] q;
    logic [BYTES-1:0][7:0] rd_byte;
    logic [BYTES:0][7:0]   rd_acc;

    // write path: each stored bit picks its byte and bit position
    for (genvar i = 0; i < N; i++) begin : g_wr
        localparam int WB = PAIRED ? 2 * i : i;
        assign q_nx[i] = (we && addr == AW'(BASE + WB / 8)) ? wdata[WB % 8] : q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_nx;
    end

    // read path: odd bits of a paired word mirror their even neighbour
    for (genvar b = 0; b < BYTES; b++) begin : g_rb
        for (genvar j = 0; j < 8; j++) begin : g_rj
            localparam int WB = 8 * b + j;
            localparam int E  = PAIRED ? WB / 2 : WB;
            if (E < N) begin : g_live
                assign rd_byte[b][j] = q[E];
            end else begin : g_pad
                assign rd_byte[b][j] = 1'b0;
            end
        end
        assign rd_acc[b+1] = rd_acc[b] | ((addr == AW'(BASE + b)) ? rd_byte[b] : 8'h00);
    end
    assign rd_acc[0] = 8'h00;
    assign rdata     = rd_acc[BYTES];

endmodule

// File: rtl/srcm_table.sv
module srcm_table #(
    parameter int N_SHORT = 24,
    parameter int N_EXT   = 12,
    parameter int AW      = 8,
    parameter int SBASE   = 0,
    parameter int XBASE   = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [AW-1:0]               addr,
    input  logic [7:0]                  wdata,
    output logic [N_SHORT-1:0][15:0]    s_nx,
    output logic [N_EXT-1:0][63:0]      x_nx
);
    logic [N_SHORT-1:0][15:0] s_q;
    logic [N_EXT-1:0][63:0]   x_q;

    for (genvar i = 0; i < N_SHORT; i++) begin : g_sh
        for (genvar k = 0; k < 2; k++) begin : g_sb
            assign s_nx[i][8*k +: 8] = (we && addr == AW'(SBASE + 2 * i + k)) ? wdata : s_q[i][8*k +: 8];
        end
    end

    for (genvar n = 0; n < N_EXT; n++) begin : g_ex
        for (genvar k = 0; k < 8; k++) begin : g_xb
            assign x_nx[n][8*k +: 8] = (we && addr == AW'(XBASE + 8 * n + k)) ? wdata : x_q[n][8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            x_q <= '0;
        end else begin
            s_q <= s_nx;
            x_q <= x_nx;
        end
    end

endmodule

// File: rtl/srcm_match.sv
module srcm_match #(
    parameter int N     = 24,
    parameter int W     = 16,
    parameter int IDX_W = 5
) (
    input  logic                  active,
    input  logic [W-1:0]          key,
    input  logic [N-1:0][W-1:0]   tbl,
    input  logic [N-1:0]          aen,
    input  logic [N-1:0]          pen,
    output logic                  hit,
    output logic [IDX_W-1:0]      idx,
    output logic                  qual
);
    logic [N-1:0]            eq;
    logic [N:0][IDX_W-1:0]   chain;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = active && aen[i] && (tbl[i] == key);
    end

    // priority chain: lower index overrides higher
    assign chain[N] = '0;
    for (genvar i = N - 1; i >= 0; i--) begin : g_pri
        assign chain[i] = eq[i] ? IDX_W'(i) : chain[i+1];
    end

    assign hit  = |eq;
    assign idx  = chain[0];
    assign qual = |(eq & pen);

endmodule

// File: rtl/srcm_engine.sv
module srcm_engine #(
    parameter int N_SHORT = 24,
    parameter int N_EXT   = 12,
    parameter int AW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          filt_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          src_valid,
    input  logic [1:0]    src_mode,
    input  logic [63:0]   src_addr,
    input  logic          src_is_dreq,
    output logic          res_valid,
    output logic          res_hit,
    output logic [4:0]    res_idx,
    output logic          res_pend,
    output logic          res_nopend
);
    import srcm_pkg::*;

    localparam int IDX_W     = 5;
    localparam int SBASE     = 0;
    localparam int XBASE     = SBASE + 2 * N_SHORT;
    localparam int CTRL_ADDR = XBASE + 8 * N_EXT;
    localparam int SW_BYTES  = (N_SHORT + 7) / 8;
    localparam int XW_BYTES  = (2 * N_EXT + 7) / 8;
    localparam int SEN_BASE  = CTRL_ADDR + 1;
    localparam int XEN_BASE  = SEN_BASE + SW_BYTES;
    localparam int SPD_BASE  = XEN_BASE + XW_BYTES;
    localparam int XPD_BASE  = SPD_BASE + SW_BYTES;

    // ---------------- control register ----------------
    logic [CTRL_BITS-1:0] ctrl_q, ctrl_nx;
    assign ctrl_nx = (bus_we && bus_addr == AW'(CTRL_ADDR)) ? bus_wdata[CTRL_BITS-1:0] : ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '1;
        else        ctrl_q <= ctrl_nx;
    end

    // ---------------- enable words ----------------
    logic [N_SHORT-1:0] sen_nx, spd_nx;
    logic [N_EXT-1:0]   xen_nx, xpd_nx;
    logic [7:0]         sen_rd, spd_rd, xen_rd, xpd_rd, ctrl_rd;

    srcm_flagword #(.N(N_SHORT), .AW(AW), .BASE(SEN_BASE), .PAIRED(1'b0)) u_sen (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .q_nx(sen_nx), .rdata(sen_rd));
    srcm_flagword #(.N(N_EXT), .AW(AW), .BASE(XEN_BASE), .PAIRED(1'b1)) u_xen (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .q_nx(xen_nx), .rdata(xen_rd));
    srcm_flagword #(.N(N_SHORT), .AW(AW), .BASE(SPD_BASE), .PAIRED(1'b0)) u_spd (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .q_nx(spd_nx), .rdata(spd_rd));
    srcm_flagword #(.N(N_EXT), .AW(AW), .BASE(XPD_BASE), .PAIRED(1'b1)) u_xpd (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .q_nx(xpd_nx), .rdata(xpd_rd));

    assign ctrl_rd   = (bus_addr == AW'(CTRL_ADDR)) ? {{(8 - CTRL_BITS){1'b0}}, ctrl_q} : 8'h00;
    assign bus_rdata = ctrl_rd | sen_rd | xen_rd | spd_rd | xpd_rd;

    // ---------------- address table ----------------
    logic [N_SHORT-1:0][15:0] s_tbl;
    logic [N_EXT-1:0][63:0]   x_tbl;

    srcm_table #(.N_SHORT(N_SHORT), .N_EXT(N_EXT), .AW(AW), .SBASE(SBASE), .XBASE(XBASE)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .s_nx(s_tbl), .x_nx(x_tbl));

    // ---------------- comparison ----------------
    logic gate, sh_act, ex_act;
    logic sh_hit, sh_qual, ex_hit, ex_qual;
    logic [IDX_W-1:0] sh_idx, ex_idx;

    assign gate   = filt_en && ctrl_nx[CB_MATCH];
    assign sh_act = gate && (src_mode == SRC_SHORT);
    assign ex_act = gate && (src_mode == SRC_EXT);

    srcm_match #(.N(N_SHORT), .W(16), .IDX_W(IDX_W)) u_msh (
        .active(sh_act), .key(src_addr[15:0]), .tbl(s_tbl), .aen(sen_nx), .pen(spd_nx),
        .hit(sh_hit), .idx(sh_idx), .qual(sh_qual));
    srcm_match #(.N(N_EXT), .W(64), .IDX_W(IDX_W)) u_mex (
        .active(ex_act), .key(src_addr), .tbl(x_tbl), .aen(xen_nx), .pen(xpd_nx),
        .hit(ex_hit), .idx(ex_idx), .qual(ex_qual));

    logic             hit_c, qual_c, dreq_ok, pend_c;
    logic [IDX_W-1:0] idx_c;

    assign hit_c   = sh_hit | ex_hit;
    assign qual_c  = sh_qual | ex_qual;
    assign idx_c   = sh_hit ? sh_idx : (ex_hit ? ex_idx : '0);
    assign dreq_ok = !ctrl_nx[CB_DREQONLY] || src_is_dreq;
    assign pend_c  = ctrl_nx[CB_AUTOPEND] && dreq_ok && qual_c;

    // ---------------- state machine ----------------
    state_e state_q, state_nx;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   state_nx = src_valid ? ST_RESULT : ST_IDLE;   // GO_RESULT / STAY_IDLE
            ST_RESULT: state_nx = src_valid ? ST_RESULT : ST_IDLE;   // HOLD_RESULT / GO_IDLE
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // result capture on the strobe
    logic             hit_q, pend_q, nopend_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q    <= 1'b0;
            pend_q   <= 1'b0;
            nopend_q <= 1'b0;
            idx_q    <= '0;
        end else if (src_valid) begin
            hit_q    <= hit_c;
            pend_q   <= pend_c;
            nopend_q <= hit_c && !qual_c;
            idx_q    <= idx_c;
        end
    end

    // output process
    always_comb begin
        res_valid  = (state_q == ST_RESULT);
        res_hit    = res_valid && hit_q;
        res_pend   = res_valid && pend_q;
        res_nopend = res_valid && nopend_q;
        res_idx    = res_valid ? idx_q : '0;
    end

endmodule

// File: rtl/srcm_engine_chk.sv
module srcm_engine_chk #(
    parameter int N_SHORT = 24,
    parameter int N_EXT   = 12,
    parameter int AW      = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          filt_en,
    input logic [AW-1:0] bus_addr,
    input logic [7:0]    bus_rdata,
    input logic          src_valid,
    input logic [1:0]    src_mode,
    input logic          res_valid,
    input logic          res_hit,
    input logic [4:0]    res_idx,
    input logic          res_pend,
    input logic          res_nopend
);
    localparam int CTRL_ADDR = 2 * N_SHORT + 8 * N_EXT;

    a_r5_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        src_valid |=> res_valid);

    a_r5_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
        !src_valid |=> !res_valid);

    a_r5_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_pend && !res_nopend && res_idx == 5'd0));

    a_r8_pend_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_pend |-> res_hit);

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        res_nopend |-> !res_pend);

    a_r11_filter_off: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !filt_en) |=> (!res_hit && !res_pend));

    a_r6_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && (src_mode == 2'b00 || src_mode == 2'b01)) |=> !res_hit);

    a_r2_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(CTRL_ADDR)) |-> (bus_rdata[7:3] == 5'd0));

endmodule

bind srcm_engine srcm_engine_chk #(.N_SHORT(N_SHORT), .N_EXT(N_EXT), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .src_valid(src_valid), .src_mode(src_mode), .res_valid(res_valid), .res_hit(res_hit),
    .res_idx(res_idx), .res_pend(res_pend), .res_nopend(res_nopend));

// File: tb/tb_srcm_engine.sv
`timescale 1ns/1ps
module tb_srcm_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        filt_en = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        src_valid = 1'b0;
    logic [1:0]  src_mode = 2'b00;
    logic [63:0] src_addr = 64'h0;
    logic        src_is_dreq = 1'b0;
    logic        res_valid, res_hit, res_pend, res_nopend;
    logic [4:0]  res_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    srcm_engine dut (
        .clk(clk), .rst_n(rst_n), .filt_en(filt_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_valid(src_valid),
        .src_mode(src_mode), .src_addr(src_addr), .src_is_dreq(src_is_dreq),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
        .res_pend(res_pend), .res_nopend(res_nopend));

    // vector: {mode[1:0], addr[63:0], dreq, filt, hit, idx[4:0], pend, nopend}
    localparam int NV = 12;
    localparam logic [75:0] VEC [NV] = '{
        {2'b10, 64'h0000_0000_0000_1234, 1'b1, 1'b1, 1'b1, 5'd0,  1'b0, 1'b1},
        {2'b10, 64'h0000_0000_0000_BEEF, 1'b1, 1'b1, 1'b1, 5'd3,  1'b1, 1'b0},
        {2'b10, 64'h0000_0000_0000_BEEF, 1'b0, 1'b1, 1'b1, 5'd3,  1'b0, 1'b0},
        {2'b10, 64'h0000_0000_0000_A5A5, 1'b1, 1'b1, 1'b1, 5'd23, 1'b1, 1'b0},
        {2'b10, 64'h0000_0000_0000_5555, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
        {2'b11, 64'h0011_2233_4455_6677, 1'b1, 1'b1, 1'b1, 5'd0,  1'b1, 1'b0},
        {2'b11, 64'hDEAD_BEEF_0102_0304, 1'b1, 1'b1, 1'b1, 5'd11, 1'b0, 1'b1},
        {2'b00, 64'h0000_0000_0000_1234, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
        {2'b01, 64'h0000_0000_0000_1234, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
        {2'b11, 64'h0000_0000_0000_1234, 1'b1, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0},
        {2'b10, 64'h0000_0000_0000_1234, 1'b1, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0},
        {2'b10, 64'hFFFF_0000_0000_BEEF, 1'b1, 1'b1, 1'b1, 5'd3,  1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, {56'h0, bus_rdata}, {56'h0, exp});
    endtask

    task automatic lookup(input logic [1:0] m, input logic [63:0] a, input logic dq, input logic f);
        @(negedge clk);
        src_mode = m; src_addr = a; src_is_dreq = dq; filt_en = f; src_valid = 1'b1;
        @(negedge clk);
        src_valid = 1'b0;
    endtask

    task automatic res_check(input string req, input logic h, input logic [4:0] i,
                             input logic p, input logic np);
        check({req, " valid"},  {63'h0, res_valid},  64'h1);
        check({req, " hit"},    {63'h0, res_hit},    {63'h0, h});
        check({req, " idx"},    {59'h0, res_idx},    {59'h0, i});
        check({req, " pend"},   {63'h0, res_pend},   {63'h0, p});
        check({req, " nopend"}, {63'h0, res_nopend}, {63'h0, np});
    endtask

    task automatic wr_short(input int e, input logic [15:0] a);
        wr(8'(2 * e), a[7:0]);
        wr(8'(2 * e + 1), a[15:8]);
    endtask

    task automatic wr_ext(input int e, input logic [63:0] a);
        for (int k = 0; k < 8; k++) wr(8'(48 + 8 * e + k), a[8*k +: 8]);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 res_valid after reset", {63'h0, res_valid}, 64'h0);
        rd_check("R1 ctrl reset", 8'h90, 8'h07);
        rd_check("R1 short enable reset", 8'h91, 8'h00);
        rd_check("R1 ext enable reset", 8'h94, 8'h00);
        rd_check("R1 ext pend reset", 8'h9C, 8'h00);

        // R2 reserved control bits
        wr(8'h90, 8'hFF);
        rd_check("R2 ctrl reserved bits", 8'h90, 8'h07);
        wr(8'h90, 8'hF8);
        rd_check("R2 ctrl cleared", 8'h90, 8'h00);
        wr(8'h90, 8'h07);

        // R3 short word byte order and readback
        wr(8'h91, 8'hA1); wr(8'h92, 8'h5C); wr(8'h93, 8'h3E);
        rd_check("R3 short en byte0", 8'h91, 8'hA1);
        rd_check("R3 short en byte1", 8'h92, 8'h5C);
        rd_check("R3 short en byte2", 8'h93, 8'h3E);
        wr(8'h98, 8'h81);
        rd_check("R3 short pend byte1", 8'h98, 8'h81);

        // R4 extended even-bit storage and mirroring
        wr(8'h94, 8'hAA);
        rd_check("R4 odd bits ignored", 8'h94, 8'h00);
        wr(8'h95, 8'h14);
        rd_check("R4 mirrored read", 8'h95, 8'h3C);
        wr(8'h9B, 8'h41);
        rd_check("R4 ext pend mirrored", 8'h9B, 8'hC3);

        // R13 table programming
        wr_short(0, 16'h1234);
        wr_short(3, 16'hBEEF);
        wr_short(5, 16'hBEEF);
        wr_short(23, 16'hA5A5);
        wr_ext(0, 64'h0011_2233_4455_6677);
        wr_ext(4, 64'hDEAD_BEEF_0102_0304);
        wr_ext(11, 64'hDEAD_BEEF_0102_0304);
        rd_check("R13 table reads zero", 8'h06, 8'h00);
        // short enable: entries 0,3,5,23; short pend: 5,23
        wr(8'h91, 8'h29); wr(8'h92, 8'h00); wr(8'h93, 8'h80);
        wr(8'h97, 8'h20); wr(8'h98, 8'h00); wr(8'h99, 8'h80);
        // ext enable: entries 0 and 11 (bits 0 and 22); ext pend: entry 0
        wr(8'h94, 8'h01); wr(8'h95, 8'h00); wr(8'h96, 8'h40);
        wr(8'h9A, 8'h01); wr(8'h9B, 8'h00); wr(8'h9C, 8'h00);
        rd_check("R4 ext enable readback low", 8'h94, 8'h03);
        rd_check("R4 ext enable readback high", 8'h96, 8'hC0);

        // vector walk: R6 R7 R8 R10 R11 R13
        for (int v = 0; v < NV; v++) begin
            lookup(VEC[v][75:74], VEC[v][73:10], VEC[v][9], VEC[v][8]);
            res_check($sformatf("R6 R7 R8 R10 R11 vector %0d", v),
                      VEC[v][7], VEC[v][6:2], VEC[v][1], VEC[v][0]);
        end
        filt_en = 1'b1;

        // R9 data-request-only off
        wr(8'h90, 8'h03);
        lookup(2'b10, 64'hBEEF, 1'b0, 1'b1);
        res_check("R9 any frame pends", 1'b1, 5'd3, 1'b1, 1'b0);
        // R8 auto-pending off
        wr(8'h90, 8'h05);
        lookup(2'b10, 64'hBEEF, 1'b1, 1'b1);
        res_check("R8 auto off", 1'b1, 5'd3, 1'b0, 1'b0);
        // R8 match enable off
        wr(8'h90, 8'h06);
        lookup(2'b10, 64'hA5A5, 1'b1, 1'b1);
        res_check("R8 match off", 1'b0, 5'd0, 1'b0, 1'b0);
        // R11 filter off with match enable set and cleared
        lookup(2'b10, 64'hA5A5, 1'b1, 1'b0);
        res_check("R11 filter off match off", 1'b0, 5'd0, 1'b0, 1'b0);
        wr(8'h90, 8'h07);
        lookup(2'b11, 64'h0011_2233_4455_6677, 1'b1, 1'b0);
        res_check("R11 filter off ext", 1'b0, 5'd0, 1'b0, 1'b0);
        filt_en = 1'b1;

        // R5 back-to-back strobes
        @(negedge clk);
        src_mode = 2'b10; src_addr = 64'hBEEF; src_is_dreq = 1'b1; src_valid = 1'b1;
        check("R5 no result in strobe cycle", {63'h0, res_valid}, 64'h0);
        @(negedge clk);
        src_addr = 64'h5555;
        res_check("R5 first of pair", 1'b1, 5'd3, 1'b1, 1'b0);
        @(negedge clk);
        src_valid = 1'b0;
        res_check("R5 second of pair", 1'b0, 5'd0, 1'b0, 1'b0);
        @(negedge clk);
        check("R5 valid drops", {63'h0, res_valid}, 64'h0);

        // R12 enable cleared in the same cycle as the strobe
        @(negedge clk);
        src_mode = 2'b10; src_addr = 64'hA5A5; src_is_dreq = 1'b1; src_valid = 1'b1;
        bus_we = 1'b1; bus_addr = 8'h93; bus_wdata = 8'h00;
        @(negedge clk);
        src_valid = 1'b0; bus_we = 1'b0;
        res_check("R12 same-cycle disable", 1'b0, 5'd0, 1'b0, 1'b0);
        rd_check("R12 write landed", 8'h93, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule